// File: doc/BRIEF.md
# Page Permission and Fault Code Checker

This block sits after a page-table walk and decides whether one memory access to an already translated page may proceed. It takes the page's combined user, writable and no-execute bits, the page's protection key, the kind of access (read, write or instruction fetch), the privilege of the access, a set of mode control bits and two protection-key rights registers. From these it forms a read/write/execute rights mask for the page and a single deny flag. When the access is denied, it also forms the page-fault error-code word.

Basic user/supervisor and writable checks come first. Three stricter rules are layered on top of them: supervisor reads of user pages can be blocked, supervisor fetches from user pages can be blocked, and per-key access-disable and write-disable rights apply. The walker may instead report a not-present entry or a reserved-bit violation. In those cases the block skips the rights checks and only builds the fault word. A parameter selects whether the result is registered, which adds one cycle, or passed through combinationally.

Top module: `page_perm_chk`

## Requirements
- R1: A user access (`acc_user`=1) to a page whose `pg_user` bit is 0 is denied. The rights output is 0 and the error code has P (bit 0) set.
- R2: Read right (rights bit 0) is granted unless `sap_idx`=1 and `pg_user`=1.
- R3: Write right (rights bit 1) is granted only together with read, and only when `pg_write`=1 or when the access is supervisor with `wp_en`=0.
- R4: Execute right (rights bit 2) is granted only when `pg_nx`=0, and either the access is user or not (`smep_en`=1 and `pg_user`=1).
- R5: Key rights take effect only when `lma_en`=1. A user page uses `ukey_rights` if `ukey_en`=1, and a supervisor page uses `skey_rights` if `skey_en`=1. Otherwise no key restriction applies.
- R6: For key k, bit 2k of the selected register removes read and write. Bit 2k+1 removes write, but only for a user access or when `wp_en`=1. A denial caused by the key sets PK (bit 5) and P.
- R7: `acc_type` is encoded as 0 read, 1 write, 2 fetch; 3 is treated as read. The access is denied when the rights bit selected by the type is clear (bit 0 read, bit 1 write, bit 2 fetch).
- R8: Error-code layout: P=0, W=1, U=2, RSVD=3, I/D=4, PK=5. On any denial, W equals (`acc_type`==1) and U equals `acc_user`.
- R9: On a denied fetch, I/D is set only when (`nxe_en`=1 and `pae_en`=1) or `smep_en`=1.
- R10: `not_present`=1 denies the access, forces the rights to 0 and leaves P, RSVD and PK clear. It takes priority over `rsvd_fault`.
- R11: `rsvd_fault`=1 (with `not_present`=0) denies the access, forces the rights to 0 and sets both P and RSVD.
- R12: With `REG_OUT`=1, the outputs appear one clock after `req_valid`. Reset and an idle cycle give all-zero outputs, and an allowed access gives error code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| pg_user | input | 1 | Combined user bit of the page |
| pg_write | input | 1 | Combined writable bit of the page |
| pg_nx | input | 1 | Combined no-execute bit of the page |
| pg_key | input | KEY_W | Protection key of the page |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch, 3 as read |
| acc_user | input | 1 | Access made at user privilege |
| wp_en | input | 1 | Supervisor write protection enable |
| smep_en | input | 1 | Block supervisor fetch from user pages |
| sap_idx | input | 1 | Supervisor access with user-page read blocking |
| nxe_en | input | 1 | No-execute enable |
| pae_en | input | 1 | Extended physical addressing enabled |
| lma_en | input | 1 | Long mode active |
| ukey_en | input | 1 | User key rights enable |
| skey_en | input | 1 | Supervisor key rights enable |
| ukey_rights | input | 2*2**KEY_W | Key rights for user pages |
| skey_rights | input | 2*2**KEY_W | Key rights for supervisor pages |
| not_present | input | 1 | Walker found a not-present entry |
| rsvd_fault | input | 1 | Walker found a reserved-bit violation |
| rsp_valid | output | 1 | Result valid |
| rights | output | 3 | Granted rights: bit0 read, bit1 write, bit2 exec |
| deny | output | 1 | Access refused |
| err_code | output | 6 | Page-fault error code |

## Verification
The bench targets the orderings between fault causes. These are: not-present against reserved, user violation against key denial, and key denial against the plain rights check. A design that gets one of these wrong sets P, RSVD or PK in the wrong combination. It also exercises the write-disable key bit for supervisor accesses with and without write protection. A wrong qualifier there would make supervisor writes fault, or never fault. Other directed cases cover fetches that should or should not carry I/D, and access type 3, which a careless decoder would map to fetch or to write.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  localparam int RB_RD = 0;
  localparam int RB_WR = 1;
  localparam int RB_EX = 2;
  localparam int RIGHTS_W = 3;

  localparam int EB_P    = 0;
  localparam int EB_W    = 1;
  localparam int EB_U    = 2;
  localparam int EB_RSVD = 3;
  localparam int EB_ID   = 4;
  localparam int EB_PK   = 5;
  localparam int ERR_W   = 6;

  typedef logic [RIGHTS_W-1:0] rights_t;
  typedef logic [ERR_W-1:0]    err_t;

  function automatic int unsigned rights_bit(input logic [1:0] t);
    case (t)
      ACC_WRITE: return RB_WR;
      ACC_FETCH: return RB_EX;
      default:   return RB_RD;
    endcase
  endfunction
endpackage

// File: rtl/ppc_base_rights.sv
module ppc_base_rights
  import ppc_pkg::*;
(
  input  logic    pg_user,
  input  logic    pg_write,
  input  logic    pg_nx,
  input  logic    acc_user,
  input  logic    wp_en,
  input  logic    smep_en,
  input  logic    sap_idx,
  output rights_t base,
  output logic    user_viol
);
  logic rd_ok, wr_ok, ex_ok;

  always_comb begin
    user_viol = acc_user && !pg_user;
    rd_ok = !(sap_idx && pg_user);
    wr_ok = rd_ok && (pg_write || (!acc_user && !wp_en));
    ex_ok = !pg_nx && (acc_user || !(smep_en && pg_user));
    base = '0;
    base[RB_RD] = rd_ok;
    base[RB_WR] = wr_ok;
    base[RB_EX] = ex_ok;
  end
endmodule

// File: rtl/ppc_key_rights.sv
module ppc_key_rights
  import ppc_pkg::*;
#(
  parameter int KEY_W = 4,
  localparam int NKEYS = 1 << KEY_W,
  localparam int KR_W = 2 * NKEYS
) (
  input  logic             pg_user,
  input  logic [KEY_W-1:0] pg_key,
  input  logic             acc_user,
  input  logic             wp_en,
  input  logic             lma_en,
  input  logic             ukey_en,
  input  logic             skey_en,
  input  logic [KR_W-1:0]  ukey_rights,
  input  logic [KR_W-1:0]  skey_rights,
  output rights_t          key_mask
);
  logic [KR_W-1:0] sel_reg;
  logic [1:0]      pair [NKEYS];
  logic [1:0]      cur;

  always_comb begin
    sel_reg = '0;
    if (lma_en) begin
      if (pg_user && ukey_en)       sel_reg = ukey_rights;
      else if (!pg_user && skey_en) sel_reg = skey_rights;
    end
  end

  for (genvar k = 0; k < NKEYS; k++) begin : g_pair
    assign pair[k] = sel_reg[2*k +: 2];
  end

  assign cur = pair[pg_key];

  always_comb begin
    key_mask = '1;
    if (cur[0]) begin
      key_mask[RB_RD] = 1'b0;
      key_mask[RB_WR] = 1'b0;
    end else if (cur[1] && (acc_user || wp_en)) begin
      key_mask[RB_WR] = 1'b0;
    end
  end
endmodule

// File: rtl/ppc_fault_code.sv
module ppc_fault_code
  import ppc_pkg::*;
(
  input  rights_t    base,
  input  logic       user_viol,
  input  rights_t    key_mask,
  input  logic [1:0] acc_type,
  input  logic       acc_user,
  input  logic       smep_en,
  input  logic       nxe_en,
  input  logic       pae_en,
  input  logic       not_present,
  input  logic       rsvd_fault,
  output rights_t    rights,
  output logic       deny,
  output err_t       err
);
  rights_t     eff;
  int unsigned sel;
  logic        key_den, plain_den;

  always_comb begin
    eff       = base & key_mask;
    sel       = rights_bit(acc_type);
    key_den   = !key_mask[sel];
    plain_den = !eff[sel];
    rights    = eff;
    deny      = 1'b0;
    err       = '0;
    if (not_present) begin
      rights = '0;
      deny   = 1'b1;
    end else if (rsvd_fault) begin
      rights        = '0;
      deny          = 1'b1;
      err[EB_P]     = 1'b1;
      err[EB_RSVD]  = 1'b1;
    end else if (user_viol) begin
      rights    = '0;
      deny      = 1'b1;
      err[EB_P] = 1'b1;
    end else if (key_den) begin
      deny       = 1'b1;
      err[EB_P]  = 1'b1;
      err[EB_PK] = 1'b1;
    end else if (plain_den) begin
      deny      = 1'b1;
      err[EB_P] = 1'b1;
    end
    if (deny) begin
      err[EB_W]  = (acc_type == ACC_WRITE);
      err[EB_U]  = acc_user;
      err[EB_ID] = (acc_type == ACC_FETCH) && ((nxe_en && pae_en) || smep_en);
    end
  end
endmodule

// File: rtl/page_perm_chk.sv
module page_perm_chk
  import ppc_pkg::*;
#(
  parameter int KEY_W = 4,
  parameter bit REG_OUT = 1'b1,
  localparam int KR_W = 2 * (1 << KEY_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             pg_user,
  input  logic             pg_write,
  input  logic             pg_nx,
  input  logic [KEY_W-1:0] pg_key,
  input  logic [1:0]       acc_type,
  input  logic             acc_user,
  input  logic             wp_en,
  input  logic             smep_en,
  input  logic             sap_idx,
  input  logic             nxe_en,
  input  logic             pae_en,
  input  logic             lma_en,
  input  logic             ukey_en,
  input  logic             skey_en,
  input  logic [KR_W-1:0]  ukey_rights,
  input  logic [KR_W-1:0]  skey_rights,
  input  logic             not_present,
  input  logic             rsvd_fault,
  output logic             rsp_valid,
  output logic [2:0]       rights,
  output logic             deny,
  output logic [5:0]       err_code
);
  rights_t base, key_mask, c_rights;
  logic    user_viol, c_deny;
  err_t    c_err;

  ppc_base_rights u_base (
    .pg_user  (pg_user),
    .pg_write (pg_write),
    .pg_nx    (pg_nx),
    .acc_user (acc_user),
    .wp_en    (wp_en),
    .smep_en  (smep_en),
    .sap_idx  (sap_idx),
    .base     (base),
    .user_viol(user_viol)
  );

  ppc_key_rights #(.KEY_W(KEY_W)) u_key (
    .pg_user    (pg_user),
    .pg_key     (pg_key),
    .acc_user   (acc_user),
    .wp_en      (wp_en),
    .lma_en     (lma_en),
    .ukey_en    (ukey_en),
    .skey_en    (skey_en),
    .ukey_rights(ukey_rights),
    .skey_rights(skey_rights),
    .key_mask   (key_mask)
  );

  ppc_fault_code u_fault (
    .base       (base),
    .user_viol  (user_viol),
    .key_mask   (key_mask),
    .acc_type   (acc_type),
    .acc_user   (acc_user),
    .smep_en    (smep_en),
    .nxe_en     (nxe_en),
    .pae_en     (pae_en),
    .not_present(not_present),
    .rsvd_fault (rsvd_fault),
    .rights     (c_rights),
    .deny       (c_deny),
    .err        (c_err)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        rsp_valid <= 1'b0;
        rights    <= '0;
        deny      <= 1'b0;
        err_code  <= '0;
      end else begin
        rsp_valid <= req_valid;
        rights    <= req_valid ? c_rights : '0;
        deny      <= req_valid && c_deny;
        err_code  <= req_valid ? c_err : '0;
      end
    end
  end else begin : g_comb
    assign rsp_valid = req_valid;
    assign rights    = req_valid ? c_rights : '0;
    assign deny      = req_valid && c_deny;
    assign err_code  = req_valid ? c_err : '0;
  end
endmodule

// File: rtl/page_perm_chk_sva.sv
module page_perm_chk_sva #(
  parameter bit REG_OUT = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       not_present,
  input logic       req_valid,
  input logic       rsp_valid,
  input logic [2:0] rights,
  input logic       deny,
  input logic [5:0] err_code
);
  p_ok_clean_r12: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !deny) |-> (err_code == 6'd0));

  p_idle_zero_r12: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!deny && err_code == 6'd0 && rights == 3'd0));

  p_rsvd_has_p_r11: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && err_code[3]) |-> (err_code[0] && deny && rights == 3'd0));

  p_pk_has_p_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && err_code[5]) |-> (err_code[0] && deny && !err_code[3]));

  p_wr_needs_rd_r3: assert property (@(posedge clk) disable iff (rst)
    rights[1] |-> rights[0]);

  if (REG_OUT) begin : g_lat
    p_np_clear_r10: assert property (@(posedge clk) disable iff (rst)
      ($past(req_valid) && $past(not_present)) |->
        (deny && !err_code[0] && !err_code[3] && !err_code[5] && rights == 3'd0));
  end
endmodule

bind page_perm_chk page_perm_chk_sva #(.REG_OUT(REG_OUT)) u_sva (
  .clk        (clk),
  .rst        (rst),
  .not_present(not_present),
  .req_valid  (req_valid),
  .rsp_valid  (rsp_valid),
  .rights     (rights),
  .deny       (deny),
  .err_code   (err_code)
);

// File: tb/page_perm_chk_tb_top.sv
module page_perm_chk_tb_top;
  localparam int CLK_P = 10;
  localparam int KW = 4;
  localparam int KRW = 2 * (1 << KW);

  logic clk = 1'b0;
  logic rst;
  logic req_valid, pg_user, pg_write, pg_nx;
  logic [KW-1:0] pg_key;
  logic [1:0] acc_type;
  logic acc_user, wp_en, smep_en, sap_idx, nxe_en, pae_en, lma_en, ukey_en, skey_en;
  logic [KRW-1:0] ukey_rights, skey_rights;
  logic not_present, rsvd_fault;
  logic rsp_valid, deny;
  logic [2:0] rights;
  logic [5:0] err_code;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  page_perm_chk #(.KEY_W(KW), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .pg_user(pg_user), .pg_write(pg_write), .pg_nx(pg_nx), .pg_key(pg_key),
    .acc_type(acc_type), .acc_user(acc_user), .wp_en(wp_en), .smep_en(smep_en),
    .sap_idx(sap_idx), .nxe_en(nxe_en), .pae_en(pae_en), .lma_en(lma_en),
    .ukey_en(ukey_en), .skey_en(skey_en), .ukey_rights(ukey_rights),
    .skey_rights(skey_rights), .not_present(not_present), .rsvd_fault(rsvd_fault),
    .rsp_valid(rsp_valid), .rights(rights), .deny(deny), .err_code(err_code)
  );

  // Expected {valid, rights, deny, err} from the requirement text
  function automatic logic [10:0] expect_out();
    logic r, w, x, kr, kw, pk, p, rs, dn, need;
    logic [KRW-1:0] kreg;
    logic [5:0] e;
    // R2, R3, R4
    r = !(sap_idx && pg_user);
    w = r && (pg_write || (!acc_user && !wp_en));
    x = !pg_nx && (acc_user || !(smep_en && pg_user));
    // R5, R6
    kreg = '0;
    if (lma_en && pg_user && ukey_en) kreg = ukey_rights;
    if (lma_en && !pg_user && skey_en) kreg = skey_rights;
    kr = !kreg[2*pg_key];
    kw = !kreg[2*pg_key] && !(kreg[2*pg_key+1] && (acc_user || wp_en));
    r = r && kr;
    w = w && kw;
    // R7
    case (acc_type)
      2'd1: begin need = w; pk = !kw; end
      2'd2: begin need = x; pk = 1'b0; end
      default: begin need = r; pk = !kr; end
    endcase
    p = 1'b1; rs = 1'b0; dn = 1'b1;
    if (not_present) begin p = 1'b0; pk = 1'b0; r = 0; w = 0; x = 0; end       // R10
    else if (rsvd_fault) begin rs = 1'b1; pk = 1'b0; r = 0; w = 0; x = 0; end  // R11
    else if (acc_user && !pg_user) begin pk = 1'b0; r = 0; w = 0; x = 0; end   // R1
    else if (!pk && need) dn = 1'b0;
    e = 6'd0;
    if (dn) begin // R8, R9
      e[0] = p; e[3] = rs; e[5] = pk;
      e[1] = (acc_type == 2'd1);
      e[2] = acc_user;
      e[4] = (acc_type == 2'd2) && ((nxe_en && pae_en) || smep_en);
    end
    return {1'b1, x, w, r, dn, e};
  endfunction

  task automatic defaults();
    req_valid = 1'b1; pg_user = 0; pg_write = 1; pg_nx = 0; pg_key = '0;
    acc_type = 2'd0; acc_user = 0; wp_en = 0; smep_en = 0; sap_idx = 0;
    nxe_en = 0; pae_en = 0; lma_en = 0; ukey_en = 0; skey_en = 0;
    ukey_rights = '0; skey_rights = '0; not_present = 0; rsvd_fault = 0;
  endtask

  // inputs already set; one edge of latency, sample at the following negedge
  task automatic run(input string tag);
    logic [10:0] exp_v, got;
    exp_v = expect_out();
    @(negedge clk);
    got = {rsp_valid, rights, deny, err_code};
    total++;
    if (got !== exp_v) begin
      bad++;
      $display("FAIL %s: got v=%0b rights=%03b deny=%0b err=%06b exp v=%0b rights=%03b deny=%0b err=%06b",
               tag, got[10], got[9:7], got[6], got[5:0],
               exp_v[10], exp_v[9:7], exp_v[6], exp_v[5:0]);
    end
  endtask

  task automatic check_lit(input string tag, input logic [10:0] lit);
    logic [10:0] got;
    got = {rsp_valid, rights, deny, err_code};
    total++;
    if (got !== lit) begin
      bad++;
      $display("FAIL %s: got %011b exp %011b", tag, got, lit);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    $display("FAIL watchdog: got hang exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    defaults();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_lit("R12 reset", 11'd0);
    rst = 1'b0;

    // R12 idle cycle gives zeros
    req_valid = 1'b0; @(negedge clk); @(negedge clk);
    check_lit("R12 idle", 11'd0);

    defaults(); run("R12 allowed supervisor read");
    // R1
    defaults(); acc_user = 1; pg_user = 0; run("R1 user on supervisor page");
    // R2
    defaults(); sap_idx = 1; pg_user = 1; run("R2 blocked supervisor read of user page");
    defaults(); sap_idx = 1; pg_user = 0; run("R2 prevention idx on supervisor page");
    // R3
    defaults(); pg_write = 0; acc_type = 2'd1; run("R3 supervisor write wp off");
    defaults(); pg_write = 0; acc_type = 2'd1; wp_en = 1; run("R3 supervisor write wp on");
    defaults(); pg_user = 1; acc_user = 1; pg_write = 0; acc_type = 2'd1; run("R3 user write readonly");
    // R4
    defaults(); pg_user = 1; smep_en = 1; acc_type = 2'd2; run("R4 smep supervisor fetch");
    defaults(); pg_user = 1; acc_user = 1; smep_en = 1; acc_type = 2'd2; run("R4 smep user fetch");
    defaults(); pg_nx = 1; acc_type = 2'd2; nxe_en = 1; pae_en = 1; run("R4 nx fetch");
    // R5
    defaults(); pg_user = 1; acc_user = 1; pg_key = 4'd3; ukey_en = 1;
    ukey_rights = 32'h40; run("R5 key ignored outside long mode");
    lma_en = 1; run("R5 user key access disable");
    defaults(); lma_en = 1; pg_key = 4'd3; ukey_en = 1; ukey_rights = 32'h40;
    run("R5 supervisor page ignores user reg");
    skey_en = 1; skey_rights = 32'h40; run("R5 supervisor key reg");
    // R6
    defaults(); lma_en = 1; skey_en = 1; pg_key = 4'd5; skey_rights = 32'h800;
    acc_type = 2'd1; run("R6 write disable sup wp off");
    wp_en = 1; run("R6 write disable sup wp on");
    defaults(); lma_en = 1; skey_en = 1; pg_key = 4'd15; skey_rights = 32'h4000_0000;
    acc_type = 2'd2; run("R6 access disable fetch");
    // R7
    defaults(); acc_type = 2'd3; pg_write = 0; wp_en = 1; run("R7 type three as read");
    defaults(); acc_type = 2'd3; sap_idx = 1; pg_user = 1; run("R7 type three denied read");
    // R9
    defaults(); pg_nx = 1; acc_type = 2'd2; nxe_en = 1; run("R9 no id without pae");
    // R10, R11, R8
    defaults(); not_present = 1; rsvd_fault = 1; acc_user = 1; acc_type = 2'd1;
    run("R10 not present priority");
    check_lit("R8 not present word", {1'b1, 3'b000, 1'b1, 6'b000110});
    defaults(); rsvd_fault = 1; acc_type = 2'd2; smep_en = 1; run("R11 reserved fetch");
    check_lit("R8 reserved word", {1'b1, 3'b000, 1'b1, 6'b011001});

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      req_valid = 1'b1;
      pg_user = 1'($urandom); pg_write = 1'($urandom); pg_nx = 1'($urandom);
      pg_key = KW'($urandom); acc_type = 2'($urandom); acc_user = 1'($urandom);
      wp_en = 1'($urandom); smep_en = 1'($urandom); sap_idx = 1'($urandom);
      nxe_en = 1'($urandom); pae_en = 1'($urandom); lma_en = 1'($urandom);
      ukey_en = 1'($urandom); skey_en = 1'($urandom);
      ukey_rights = ($urandom % 4 == 0) ? '0 : KRW'($urandom);
      skey_rights = ($urandom % 4 == 0) ? '0 : KRW'($urandom);
      not_present = ($urandom % 8 == 0);
      rsvd_fault = ($urandom % 8 == 0);
      run("random R8");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule